// File: doc/BRIEF.md
# Interprocessor Miscellaneous Control Register

This block is a 64-bit control and status register shared by four processors. It holds one interval-timer interrupt flag and one interprocessor interrupt flag per processor. It also holds two 4-bit arbitration tracking fields and a 4-bit general read/write field. Address decode is done elsewhere. The block sees one write strobe with 64 bits of write data. It also sees the 2-bit index of the processor that is reading, and a timer-set pulse for each processor.

Each field has its own write rule:
- Timer flags and interprocessor flags are cleared by writing ones to them.
- A separate request nibble sets interprocessor flags.
- The arbitration-try field is write-one-to-set.
- The arbitration-won field takes written ones only while it is zero.
- A clear control empties both arbitration fields.
- The general field is overwritten on every write.

Timer flags are set only by the hardware pulses. Each processor gets an interprocessor interrupt line and a timer interrupt line that follow its stored flags.

The arbitration-won field is tracked by a two-state machine. In state ARB_OPEN the field is zero and accepts written ones. In state ARB_CLAIMED it is non-zero and frozen. The transition OPEN→CLAIMED fires on a write, without the clear control, that carries any won bit. The transition CLAIMED→OPEN fires on a write with the clear control.

Top module: `imc_misc_reg`

## Requirements
- R1: A synchronous active-high reset clears every stored field, so a read then returns only the requester index and all interrupt outputs are low.
- R2: A read returns the requester's 2-bit index in bits 1:0. All bits outside bits 1:0, 4-11, 16-23 and 40-43 read as zero whatever was written.
- R3: Writing a one to bit 4+i clears timer flag i. A write never sets a timer flag.
- R4: A pulse on `tmr_pulse[i]` sets timer flag i on the next clock edge. If a write clears the same flag in that cycle, the set wins.
- R5: Writing a one to bit 8+i clears interprocessor flag i. Cycles without a write leave the flag unchanged.
- R6: Writing a one to request bit 12+i sets interprocessor flag i, and wins over a clear of the same flag in the same write. The request bits read back as zero.
- R7: Writing ones to bits 20-23 sets those arbitration-try bits, and they stay set until an arbitration clear.
- R8: Bits 16-19 (arbitration-won) take the written ones only while the field is zero. Once the field is non-zero, further writes leave it unchanged until an arbitration clear.
- R9: A write with bit 24 set clears bits 16-23 and sets none of them in that write. Bit 24 itself reads as zero.
- R10: Bits 40-43 take the written value on every write.
- R11: `ipi_irq[i]` equals stored bit 8+i and `tmr_irq[i]` equals stored bit 4+i, so each line drops only when its flag is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Write data |
| rd_cpu | input | 2 | Index of the reading processor |
| tmr_pulse | input | 4 | Per-processor timer-set pulses |
| rd_data | output | 64 | Read value including requester index |
| ipi_irq | output | 4 | Interprocessor interrupt per processor |
| tmr_irq | output | 4 | Timer interrupt per processor |

## Verification
Some cases are hard to reach from the ports:
- The arbitration-won field ignoring a second write needs the ARB_CLAIMED state to be entered first.
- The timer set has to win against a clear of the same flag in the same cycle.

The bench handles both with nested sweeps over all 16×16 pairs of nibbles. For the arbitration fields, each pair is applied as an opening write followed by a second write, and then a clear write that also carries arbitration bits. For the timer flags, each pair is applied as a pulse pattern landing in the same cycle as a clear pattern. Request and clear nibbles for the interprocessor flags are swept the same way, both in separate writes and in one write.

// File: rtl/imc_pkg.sv
package imc_pkg;
    localparam int NUM_CPU  = 4;
    localparam int DATA_W   = 64;
    localparam int ID_W     = $clog2(NUM_CPU);
    localparam int TMR_LSB  = 4;
    localparam int IPI_LSB  = 8;
    localparam int REQ_LSB  = 12;
    localparam int WON_LSB  = 16;
    localparam int TRY_LSB  = 20;
    localparam int ACL_BIT  = 24;
    localparam int GEN_LSB  = 40;
    localparam int GEN_W    = 4;
    localparam int ARB_W    = 4;

    typedef enum logic {
        ARB_OPEN    = 1'b0,
        ARB_CLAIMED = 1'b1
    } arb_state_e;
endpackage

// File: rtl/imc_flag_bank.sv
module imc_flag_bank
    import imc_pkg::*;
#(
    parameter int NCPU = NUM_CPU
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [NCPU-1:0] tmr_clr,
    input  logic [NCPU-1:0] ipi_clr,
    input  logic [NCPU-1:0] ipi_req,
    input  logic [NCPU-1:0] tmr_set,
    output logic [NCPU-1:0] tmr_q,
    output logic [NCPU-1:0] ipi_q
);
    for (genvar g = 0; g < NCPU; g++) begin : g_cpu
        // Timer flag: hardware set beats software clear
        always_ff @(posedge clk) begin
            if (rst)
                tmr_q[g] <= 1'b0;
            else if (tmr_set[g])
                tmr_q[g] <= 1'b1;
            else if (wr_en && tmr_clr[g])
                tmr_q[g] <= 1'b0;
        end

        // Interprocessor flag: request beats clear
        always_ff @(posedge clk) begin
            if (rst)
                ipi_q[g] <= 1'b0;
            else if (wr_en) begin
                if (ipi_req[g])
                    ipi_q[g] <= 1'b1;
                else if (ipi_clr[g])
                    ipi_q[g] <= 1'b0;
            end
        end

        a_r4_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst)
            tmr_set[g] |=> tmr_q[g]);
        a_r3_no_clear_without_write: assert property (@(posedge clk) disable iff (rst)
            !wr_en |=> !$fell(tmr_q[g]));
        a_r6_request_sets_flag: assert property (@(posedge clk) disable iff (rst)
            (wr_en && ipi_req[g]) |=> ipi_q[g]);
        a_r5_ipi_idle_hold: assert property (@(posedge clk) disable iff (rst)
            !wr_en |=> $stable(ipi_q[g]));
    end
endmodule

// File: rtl/imc_arb_track.sv
module imc_arb_track
    import imc_pkg::*;
#(
    parameter int W = ARB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         acl,
    input  logic [W-1:0] try_wr,
    input  logic [W-1:0] won_wr,
    output logic [W-1:0] try_q,
    output logic [W-1:0] won_q
);
    arb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ARB_OPEN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_OPEN:    if (wr_en && !acl && (won_wr != '0)) state_d = ARB_CLAIMED;
            ARB_CLAIMED: if (wr_en && acl)                    state_d = ARB_OPEN;
            default:     state_d = ARB_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            try_q <= '0;
            won_q <= '0;
        end else if (wr_en) begin
            if (acl) begin
                try_q <= '0;
                won_q <= '0;
            end else begin
                try_q <= try_q | try_wr;
                if (state_q == ARB_OPEN)
                    won_q <= won_q | won_wr;
            end
        end
    end

    a_r8_state_tracks_won: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARB_CLAIMED) == (won_q != '0));
    a_r8_won_frozen: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARB_CLAIMED && !(wr_en && acl)) |=> $stable(won_q));
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acl) |=> (try_q == '0 && won_q == '0));
    a_r7_try_sticky: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && acl) |=> ((try_q & $past(try_q)) == $past(try_q)));
endmodule

// File: rtl/imc_misc_reg.sv
module imc_misc_reg
    import imc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ID_W-1:0]   rd_cpu,
    input  logic [NUM_CPU-1:0] tmr_pulse,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CPU-1:0] ipi_irq,
    output logic [NUM_CPU-1:0] tmr_irq
);
    logic [NUM_CPU-1:0] tmr_q, ipi_q;
    logic [ARB_W-1:0]   try_q, won_q;
    logic [GEN_W-1:0]   gen_q;

    imc_flag_bank #(.NCPU(NUM_CPU)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .tmr_clr (wr_data[TMR_LSB +: NUM_CPU]),
        .ipi_clr (wr_data[IPI_LSB +: NUM_CPU]),
        .ipi_req (wr_data[REQ_LSB +: NUM_CPU]),
        .tmr_set (tmr_pulse),
        .tmr_q   (tmr_q),
        .ipi_q   (ipi_q)
    );

    imc_arb_track #(.W(ARB_W)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .acl    (wr_data[ACL_BIT]),
        .try_wr (wr_data[TRY_LSB +: ARB_W]),
        .won_wr (wr_data[WON_LSB +: ARB_W]),
        .try_q  (try_q),
        .won_q  (won_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            gen_q <= '0;
        else if (wr_en)
            gen_q <= wr_data[GEN_LSB +: GEN_W];
    end

    always_comb begin
        rd_data = '0;
        rd_data[ID_W-1:0]             = rd_cpu;
        rd_data[TMR_LSB +: NUM_CPU]   = tmr_q;
        rd_data[IPI_LSB +: NUM_CPU]   = ipi_q;
        rd_data[WON_LSB +: ARB_W]     = won_q;
        rd_data[TRY_LSB +: ARB_W]     = try_q;
        rd_data[GEN_LSB +: GEN_W]     = gen_q;
    end

    assign ipi_irq = ipi_q;
    assign tmr_irq = tmr_q;

    a_r10_gen_follows_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[GEN_LSB +: GEN_W] == $past(wr_data[GEN_LSB +: GEN_W])));
    a_r11_ipi_line_matches: assert property (@(posedge clk) disable iff (rst)
        ipi_irq == rd_data[IPI_LSB +: NUM_CPU]);
    a_r11_tmr_line_matches: assert property (@(posedge clk) disable iff (rst)
        tmr_irq == rd_data[TMR_LSB +: NUM_CPU]);
endmodule

// File: tb/imc_misc_reg_test.sv
module imc_misc_reg_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_cpu = '0;
    logic [3:0]  tmr_pulse = '0;
    logic [63:0] rd_data;
    logic [3:0]  ipi_irq, tmr_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [3:0] m_tmr = '0, m_ipi = '0, m_try = '0, m_won = '0, m_gen = '0;

    always #5 clk = ~clk;

    imc_misc_reg uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_cpu(rd_cpu), .tmr_pulse(tmr_pulse),
        .rd_data(rd_data), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
    );

    task automatic step(input logic w, input logic [63:0] d, input logic [3:0] p);
        @(negedge clk);
        wr_en = w; wr_data = d; tmr_pulse = p;
        @(posedge clk);
        if (w) begin
            m_ipi = (m_ipi & ~d[11:8]) | d[15:12];
            m_tmr = m_tmr & ~d[7:4];
            if (d[24]) begin
                m_try = '0; m_won = '0;
            end else begin
                m_try = m_try | d[23:20];
                if (m_won == 4'h0) m_won = d[19:16];
            end
            m_gen = d[43:40];
        end
        m_tmr = m_tmr | p;
        #1;
        wr_en = 1'b0; wr_data = '0; tmr_pulse = '0;
    endtask

    task automatic check(input logic [1:0] id, input string tag);
        logic [63:0] exp;
        @(negedge clk);
        rd_cpu = id;
        #1;
        exp = '0;
        exp[1:0] = id; exp[7:4] = m_tmr; exp[11:8] = m_ipi;
        exp[19:16] = m_won; exp[23:20] = m_try; exp[43:40] = m_gen;
        n_chk++;
        if (rd_data !== exp || ipi_irq !== m_ipi || tmr_irq !== m_tmr) begin
            n_fail++;
            $display("FAIL %s: rd=%h ipi=%h tmr=%h expected rd=%h ipi=%h tmr=%h",
                     tag, rd_data, ipi_irq, tmr_irq, exp, m_ipi, m_tmr);
        end
    endtask

    function automatic logic [63:0] arbw(input logic acl, input logic [3:0] t, input logic [3:0] w);
        logic [63:0] d = '0;
        d[24] = acl; d[23:20] = t; d[19:16] = w;
        return d;
    endfunction

    initial begin : watchdog
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state, R2 requester index
        for (int id = 0; id < 4; id++) check(id[1:0], "R1/R2 reset and index");

        // R5 R6 R11: interprocessor flags, separate writes then same write
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                step(1'b1, 64'(s) << 12, 4'h0);
                step(1'b1, 64'(c) << 8, 4'h0);
                check(2'(c), "R5 ipi clear / R11 line");
                step(1'b1, (64'(s) << 12) | (64'(c) << 8), 4'h0);
                check(2'(s), "R6 request beats clear");
            end
        end
        step(1'b1, 64'h0000_0000_0000_0F00, 4'h0);

        // R3 R4 R11: timer flags, pulse vs clear in the same cycle
        for (int p = 0; p < 16; p++) begin
            for (int c = 0; c < 16; c++) begin
                step(1'b0, '0, 4'(p));
                check(2'(p), "R4 pulse sets / R11 line");
                step(1'b1, 64'(c) << 4, 4'(p ^ c));
                check(2'(c), "R3 clear vs R4 set priority");
                step(1'b1, 64'h0000_0000_0000_F000, 4'h0);
                check(2'(p), "R3 write never sets timer flag");
                step(1'b1, 64'h0000_0000_0000_0FF0, 4'h0);
            end
        end

        // R7 R8 R9: arbitration fields
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(1'b1, arbw(1'b1, 4'h0, 4'h0), 4'h0);
                check(2'(a), "R9 clear");
                step(1'b1, arbw(1'b0, 4'(a), 4'(a)), 4'h0);
                check(2'(b), "R7/R8 first write");
                step(1'b1, arbw(1'b0, 4'(b), 4'(b)), 4'h0);
                check(2'(a), "R7 try sets / R8 won frozen");
                step(1'b1, arbw(1'b1, 4'(b), 4'(a)), 4'h0);
                check(2'(b), "R9 clear sets nothing");
            end
        end

        // R10 general field, R2/R6/R9 undefined and control bits read zero
        for (int v = 0; v < 16; v++) begin
            step(1'b1, (64'(v) << 40) | 64'hFFFF_F0FF_1F00_F00C, 4'h0);
            check(2'(v), "R10 gen field / R2 zero bits");
        end
        step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0);
        check(2'd3, "R2 all-ones write / R6 R9");

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        m_tmr = '0; m_ipi = '0; m_try = '0; m_won = '0; m_gen = '0;
        check(2'd1, "R1 reset clears");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule